// File: doc/BRIEF.md
# Program Counter Control Unit

This unit sits beside the program counter of a core whose only instruction is a data move. The core has no branch opcodes. To change control flow, software moves a value to one of several destination addresses owned by this unit. The address chooses the action and the moved value is its operand. The available actions are an absolute jump, a relative branch taken on a nonzero condition, a subroutine call, a conditional return, and a write that loads the condition value used by the branch and the return. In any cycle with no accepted action, the unit steps the fetch address by one.

Moves arrive on `NUM_BUS` parallel transport buses. Each bus has a valid bit, a destination address and a data word. A move is accepted in a cycle where its valid bit and `mv_ready` are both high. `mv_ready` is low exactly when `stall` is high. While it is low, no move is taken, and a source that still needs its move to land must hold it until `mv_ready` returns. Results appear on the outputs one clock after acceptance: the new fetch address, the return-stack depth and the two error pulses.

Top module: `pc_ctrl_unit`

## Requirements
- R1: While reset is held, `fetch_pc` equals `RESET_PC`, `stack_depth` is 0, the condition value is 0, and `ovf` and `unf` are low.
- R2: In an unstalled cycle, if no bus carries a valid move to an address in `BASE_ADDR` .. `BASE_ADDR+4`, `fetch_pc` advances by one, wrapping modulo 2^`PC_W`. Moves to any other address leave the unit's state untouched.
- R3: A move to `BASE_ADDR+0` loads the moved value into `fetch_pc` unconditionally.
- R4: A move to `BASE_ADDR+1` sets `fetch_pc` to `fetch_pc` plus the moved value, read as a two's-complement offset, when the condition value is nonzero. When the condition value is zero, `fetch_pc` advances by one.
- R5: A move to `BASE_ADDR+4` stores the moved value as the condition value, and `fetch_pc` advances by one.
- R6: A move to `BASE_ADDR+2` pushes `fetch_pc+1` onto the return stack, loads the moved value into `fetch_pc`, and raises `stack_depth` by one. `stack_depth` never exceeds `RS_DEPTH` (8).
- R7: A move to `BASE_ADDR+3` with a nonzero condition value pops the top return address into `fetch_pc`. With a zero condition value, `fetch_pc` advances by one and the stack is untouched. The moved value is ignored.
- R8: A call while `stack_depth` equals `RS_DEPTH` pushes nothing. `fetch_pc` advances by one and `ovf` is high for the following cycle.
- R9: A taken return while `stack_depth` is 0 pops nothing. `fetch_pc` advances by one and `unf` is high for the following cycle.
- R10: When several buses carry valid moves to the unit in one cycle, only the lowest-numbered of them acts. Bus 0 occupies the low slice of `mv_addr` and `mv_data`.
- R11: While `stall` is high, `mv_ready` is low, and `fetch_pc`, `stack_depth`, the condition value, `ovf` and `unf` all hold their values.
- R12: Return addresses come back in last-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freezes the unit and withdraws ready |
| mv_valid | input | NUM_BUS | One valid bit per bus |
| mv_addr | input | NUM_BUS*ADDR_W | Destination address per bus, bus 0 in the low bits |
| mv_data | input | NUM_BUS*PC_W | Moved value per bus, bus 0 in the low bits |
| mv_ready | output | 1 | The unit accepts moves this cycle |
| fetch_pc | output | PC_W | Next instruction fetch address |
| stack_depth | output | $clog2(RS_DEPTH+1) | Number of entries on the return stack |
| ovf | output | 1 | One-cycle pulse after a call into a full stack |
| unf | output | 1 | One-cycle pulse after a taken return from an empty stack |

## Verification
Every result of an accepted move is due exactly one clock after the edge that accepts it. This holds for the new `fetch_pc`, the changed depth, the error pulses and the stored condition value, which is observed through the next branch or return. The bench drives each move just after a falling edge. After the next rising edge, it advances a behavioural model built from a queue and integers. It then compares every output at the following falling edge, so each check samples the cycle in which the result first becomes visible. Stalled cycles are compared in the same way and must show no change at all.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_JUMP,
    ACT_BNZ,
    ACT_CALL,
    ACT_RET,
    ACT_COND
  } pcu_act_e;
endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
  import pcu_pkg::*;
#(
  parameter int NUM_BUS   = 2,
  parameter int ADDR_W    = 8,
  parameter int PC_W      = 16,
  parameter int BASE_ADDR = 'h40
) (
  input  logic                      en,
  input  logic [NUM_BUS-1:0]        valid,
  input  logic [NUM_BUS*ADDR_W-1:0] addr,
  input  logic [NUM_BUS*PC_W-1:0]   data,
  output pcu_act_e                  act,
  output logic [PC_W-1:0]           arg
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);
  localparam int NUM_SLOTS = 5;

  logic [ADDR_W-1:0] off [NUM_BUS];
  logic [NUM_BUS-1:0] hit;

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    assign off[b] = addr[b*ADDR_W +: ADDR_W] - BASE;
    assign hit[b] = valid[b] && (addr[b*ADDR_W +: ADDR_W] >= BASE)
                    && (off[b] < ADDR_W'(NUM_SLOTS));
  end

  // Scan from the top so the lowest-numbered hitting bus is written last.
  always_comb begin
    act = ACT_NONE;
    arg = '0;
    for (int b = NUM_BUS - 1; b >= 0; b--) begin
      if (en && hit[b]) begin
        arg = data[b*PC_W +: PC_W];
        case (off[b])
          ADDR_W'(0): act = ACT_JUMP;
          ADDR_W'(1): act = ACT_BNZ;
          ADDR_W'(2): act = ACT_CALL;
          ADDR_W'(3): act = ACT_RET;
          default:    act = ACT_COND;
        endcase
      end
    end
  end
endmodule

// File: rtl/pcu_rstack.sv
module pcu_rstack #(
  parameter int W       = 16,
  parameter int DEPTH   = 8,
  parameter int DEPTH_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic               pop,
  input  logic [W-1:0]       wdata,
  output logic [W-1:0]       rdata,
  output logic [DEPTH_W-1:0] depth,
  output logic               full,
  output logic               empty
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]       mem [DEPTH];
  logic [DEPTH_W-1:0] top_idx;

  assign full    = (depth == DEPTH_W'(DEPTH));
  assign empty   = (depth == '0);
  assign top_idx = depth - 1'b1;
  assign rdata   = mem[top_idx[IW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth <= '0;
    end else if (push && !full) begin
      depth <= depth + 1'b1;
    end else if (pop && !empty) begin
      depth <= depth - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full) mem[depth[IW-1:0]] <= wdata;
  end
endmodule

// File: rtl/pc_ctrl_unit.sv
module pc_ctrl_unit
  import pcu_pkg::*;
#(
  parameter int NUM_BUS   = 2,
  parameter int ADDR_W    = 8,
  parameter int PC_W      = 16,
  parameter int BASE_ADDR = 'h40,
  parameter int RS_DEPTH  = 8,
  parameter int RESET_PC  = 0,
  parameter int DEPTH_W   = $clog2(RS_DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      stall,
  input  logic [NUM_BUS-1:0]        mv_valid,
  input  logic [NUM_BUS*ADDR_W-1:0] mv_addr,
  input  logic [NUM_BUS*PC_W-1:0]   mv_data,
  output logic                      mv_ready,
  output logic [PC_W-1:0]           fetch_pc,
  output logic [DEPTH_W-1:0]        stack_depth,
  output logic                      ovf,
  output logic                      unf
);
  pcu_act_e        act;
  logic [PC_W-1:0] arg;
  logic [PC_W-1:0] pc_q, pc_inc, pc_d, cond_q, ret_addr;
  logic            adv, cond_nz, push, pop, full, empty, ovf_d, unf_d;

  assign adv      = ~stall;
  assign mv_ready = adv;
  assign fetch_pc = pc_q;
  assign pc_inc   = pc_q + 1'b1;
  assign cond_nz  = |cond_q;

  pcu_decode #(
    .NUM_BUS(NUM_BUS), .ADDR_W(ADDR_W), .PC_W(PC_W), .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .en(adv), .valid(mv_valid), .addr(mv_addr), .data(mv_data),
    .act(act), .arg(arg)
  );

  pcu_rstack #(.W(PC_W), .DEPTH(RS_DEPTH), .DEPTH_W(DEPTH_W)) u_rs (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .wdata(pc_inc),
    .rdata(ret_addr), .depth(stack_depth), .full(full), .empty(empty)
  );

  always_comb begin
    pc_d  = pc_inc;
    push  = 1'b0;
    pop   = 1'b0;
    ovf_d = 1'b0;
    unf_d = 1'b0;
    case (act)
      ACT_JUMP: pc_d = arg;
      ACT_BNZ:  if (cond_nz) pc_d = pc_q + arg;
      ACT_CALL: begin
        if (full) ovf_d = 1'b1;
        else begin
          push = 1'b1;
          pc_d = arg;
        end
      end
      ACT_RET: begin
        if (cond_nz) begin
          if (empty) unf_d = 1'b1;
          else begin
            pop  = 1'b1;
            pc_d = ret_addr;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= PC_W'(RESET_PC);
      cond_q <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else if (adv) begin
      pc_q <= pc_d;
      ovf  <= ovf_d;
      unf  <= unf_d;
      if (act == ACT_COND) cond_q <= arg;
    end
  end
endmodule

// File: rtl/pc_ctrl_chk.sv
module pc_ctrl_chk #(
  parameter int NUM_BUS   = 2,
  parameter int ADDR_W    = 8,
  parameter int PC_W      = 16,
  parameter int BASE_ADDR = 'h40,
  parameter int RS_DEPTH  = 8,
  parameter int DEPTH_W   = $clog2(RS_DEPTH + 1)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      stall,
  input logic [NUM_BUS-1:0]        mv_valid,
  input logic [NUM_BUS*ADDR_W-1:0] mv_addr,
  input logic [NUM_BUS*PC_W-1:0]   mv_data,
  input logic [PC_W-1:0]           fetch_pc,
  input logic [DEPTH_W-1:0]        stack_depth,
  input logic                      ovf,
  input logic                      unf
);
  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(fetch_pc) && $stable(stack_depth));
  // R6
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_depth <= DEPTH_W'(RS_DEPTH));
  // R8
  ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> stack_depth == DEPTH_W'(RS_DEPTH));
  // R9
  unf_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> stack_depth == '0);
  // R3
  jump_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stall && mv_valid[0] && mv_addr[ADDR_W-1:0] == ADDR_W'(BASE_ADDR)
    |=> fetch_pc == $past(mv_data[PC_W-1:0]));
  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf));
endmodule

bind pc_ctrl_unit pc_ctrl_chk #(
  .NUM_BUS(NUM_BUS), .ADDR_W(ADDR_W), .PC_W(PC_W), .BASE_ADDR(BASE_ADDR),
  .RS_DEPTH(RS_DEPTH), .DEPTH_W(DEPTH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .mv_valid(mv_valid),
  .mv_addr(mv_addr), .mv_data(mv_data), .fetch_pc(fetch_pc),
  .stack_depth(stack_depth), .ovf(ovf), .unf(unf)
);

// File: tb/tb_pc_ctrl_unit.sv
`timescale 1ns/1ps
module tb_pc_ctrl_unit;
  localparam int NB = 2, AW = 8, PW = 16, BASE = 'h40, DEPTH = 8;
  localparam int MASK = (1 << PW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stall = 1'b0;
  logic [NB-1:0] mv_valid = '0;
  logic [NB*AW-1:0] mv_addr = '0;
  logic [NB*PW-1:0] mv_data = '0;
  logic mv_ready, ovf, unf;
  logic [PW-1:0] fetch_pc;
  logic [3:0] stack_depth;

  always #2 clk = ~clk;

  pc_ctrl_unit #(.NUM_BUS(NB), .ADDR_W(AW), .PC_W(PW), .BASE_ADDR(BASE),
                 .RS_DEPTH(DEPTH), .RESET_PC(0)) dut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .mv_valid(mv_valid),
    .mv_addr(mv_addr), .mv_data(mv_data), .mv_ready(mv_ready),
    .fetch_pc(fetch_pc), .stack_depth(stack_depth), .ovf(ovf), .unf(unf));

  int checks = 0, fails = 0;
  int m_pc = 0, m_cond = 0;
  int m_q[$];
  bit m_ovf = 0, m_unf = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "fetch_pc", int'(fetch_pc), m_pc);
    chk(tag, "depth", int'(stack_depth), m_q.size());
    chk(tag, "ovf", int'(ovf), int'(m_ovf));
    chk(tag, "unf", int'(unf), int'(m_unf));
    chk(tag, "ready", int'(mv_ready), int'(!stall));
  endtask

  function automatic bit in_unit(int a);
    return a >= BASE && a <= BASE + 4;
  endfunction

  function automatic void model(bit st, bit v0, int a0, int d0, bit v1, int a1, int d1);
    int off, d, nxt;
    bit any;
    if (st) return;
    any = 1'b0;
    off = 0;
    d = 0;
    if (v0 && in_unit(a0)) begin any = 1'b1; off = a0 - BASE; d = d0; end
    else if (v1 && in_unit(a1)) begin any = 1'b1; off = a1 - BASE; d = d1; end
    m_ovf = 0;
    m_unf = 0;
    nxt = (m_pc + 1) & MASK;
    if (any) begin
      case (off)
        0: nxt = d;
        1: if (m_cond != 0) nxt = (m_pc + d) & MASK;
        2: if (m_q.size() == DEPTH) m_ovf = 1;
           else begin m_q.push_back((m_pc + 1) & MASK); nxt = d; end
        3: if (m_cond != 0) begin
             if (m_q.size() == 0) m_unf = 1;
             else nxt = m_q.pop_back();
           end
        default: m_cond = d;
      endcase
    end
    m_pc = nxt;
  endfunction

  task automatic step(string tag, bit st, bit v0, int a0, int d0, bit v1, int a1, int d1);
    stall = st;
    mv_valid = {v1, v0};
    mv_addr = {AW'(a1), AW'(a0)};
    mv_data = {PW'(d1), PW'(d0)};
    @(posedge clk);
    model(st, v0, a0, d0 & MASK, v1, a1, d1 & MASK);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic mv(string tag, int off, int d);
    step(tag, 1'b0, 1'b1, BASE + off, d, 1'b0, 0, 0);
  endtask

  task automatic idle(string tag);
    step(tag, 1'b0, 1'b0, 0, 0, 1'b0, 0, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    idle("R2"); idle("R2");
    step("R2", 1'b0, 1'b1, BASE + 5, 'h777, 1'b1, 'h10, 'h888);
    mv("R3", 0, 'h100);
    mv("R5", 4, 0);
    mv("R4", 1, 5);
    mv("R5", 4, 3);
    mv("R4", 1, 'hFFFE);
    mv("R4", 1, 'h20);
    mv("R6", 2, 'h200);
    idle("R6");
    mv("R6", 2, 'h300);
    mv("R7", 3, 'h1234);
    mv("R12", 3, 0);
    mv("R9", 3, 0);
    for (int i = 0; i < DEPTH; i++) mv("R6", 2, 'h400 + 16 * i);
    mv("R8", 2, 'h999);
    idle("R8");
    for (int i = 0; i < DEPTH; i++) mv("R12", 3, 0);
    mv("R9", 3, 0);
    mv("R6", 2, 'h50);
    mv("R5", 4, 0);
    mv("R7", 3, 0);
    step("R10", 1'b0, 1'b1, BASE, 'h500, 1'b1, BASE, 'h600);
    step("R10", 1'b0, 1'b1, 'h13, 'h500, 1'b1, BASE, 'h600);
    step("R10", 1'b0, 1'b1, BASE + 4, 7, 1'b1, BASE, 'h700);
    mv("R10", 3, 0);
    step("R11", 1'b1, 1'b1, BASE, 'h900, 1'b0, 0, 0);
    step("R11", 1'b1, 1'b1, BASE + 2, 'h900, 1'b1, BASE + 4, 0);
    step("R11", 1'b1, 1'b1, BASE + 4, 0, 1'b0, 0, 0);
    mv("R11", 1, 'h40);
    m_q.delete();
    rst_n = 1'b0;
    m_pc = 0; m_cond = 0; m_ovf = 0; m_unf = 0;
    stall = 1'b0; mv_valid = '0;
    @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    for (int i = 0; i < 500; i++) begin
      bit st, v0, v1;
      int a0, a1;
      st = ($urandom % 8) == 0;
      v0 = $urandom % 2;
      v1 = $urandom % 2;
      a0 = BASE + int'($urandom % 7);
      a1 = BASE + int'($urandom % 7);
      step("R2", st, v0, a0, ($urandom % 3 == 0) ? 0 : int'($urandom & MASK),
           v1, a1, int'($urandom & MASK));
    end
    finish_run();
  end
endmodule